// File: doc/BRIEF.md
# SHA-1 Double-Step Compression Core

This core runs the SHA-1 compression function on one 512-bit block that the caller has already padded, and it produces a 160-bit digest. Each register update advances the five working words by two consecutive hash steps. The 80 steps of a block therefore take 40 compute cycles. The value that the first step of a pair produces goes into `b`, and the second step's `a` is built from it in the same cycle. The other three words come straight from the old register contents.

A block is handed over with a valid/ready handshake. The same handshake carries `chain_en`, which chooses the starting state. When it is low, the core starts from the standard initial vector. When it is high, it starts from the digest currently on the output. The caller uses this to hash a multi-block message one block at a time. The core keeps a 16-word sliding message schedule that yields two schedule words per cycle, and it picks the round function and the constant from the step-pair count. When a block finishes, `done` pulses for one cycle and the new digest is already on `digest`.

Top module: `sha1_dual_core`

## Requirements
- R1: After reset, `blk_ready` is 1, `done` is 0 and `digest` holds the initial vector 67452301 EFCDAB89 98BADCFE 10325476 C3D2E1F0, with the first word in bits 159:128.
- R2: A block is accepted on a rising edge where `blk_valid` and `blk_ready` are both 1. From the next cycle `blk_ready` stays 0 until the cycle in which `done` is 1.
- R3: `done` is 1 for exactly one cycle. That cycle is the one after the 42nd rising edge counted from the accepting edge, with the accepting edge counted as the first.
- R4: With `chain_en` low at acceptance, `digest` equals the SHA-1 compression of the block from the initial vector, plus the initial vector word by word modulo 2^32. Message word 0 is taken from `blk_data[511:480]` and word 15 from bits 31:0. The round functions are choose, parity, majority and parity, with constants 5A827999, 6ED9EBA1, 8F1BBCDC and CA62C1D6, each used for 20 steps.
- R5: With `chain_en` high at acceptance, the starting state and the chaining addend are the `digest` value present at acceptance, using the same word order as R4.
- R6: `blk_valid` and `blk_data` have no effect while `blk_ready` is 0. The block in flight yields its own digest, and no extra `done` follows.
- R7: `digest` changes only in a cycle where `done` is 1 and holds its value at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| blk_valid | input | 1 | A padded block is offered |
| blk_ready | output | 1 | Core is idle and takes a block this cycle |
| blk_data | input | 512 | Padded block, word 0 in bits 511:480 |
| chain_en | input | 1 | 1: start from current digest, 0: start from the initial vector |
| digest | output | 160 | Result, word a in bits 159:128 |
| done | output | 1 | One-cycle pulse when a new digest is presented |

## Verification
The bench sweeps many blocks: the three-byte reference message, an all-zero block, an all-ones block and a long pseudo-random series that alternates the chaining choice. A wrong boundary for a round function or constant, or a wrong tap or offset in the two-word schedule, would change every digest. A wrong operand order in the fused step, such as using unrotated `b` for the second step's `f`, would fail as well. A chaining mistake would show up only on the alternate blocks, where the core would restart from the initial vector. The bench also offers a different block while the core is busy, so a core that did not stall would be caught by a lost digest or a second `done`. It checks the exact cycle of `done` and that `digest` holds while the core is idle, which catches an off-by-one in the pair count and a digest register that is written early.

// File: rtl/sha1_dual_core.sv
module sha1_dual_core (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         blk_valid,
  output logic         blk_ready,
  input  logic [511:0] blk_data,
  input  logic         chain_en,
  output logic [159:0] digest,
  output logic         done
);
  localparam int PAIRS = 40;
  localparam logic [5:0] LAST = 6'(PAIRS - 1);
  localparam logic [159:0] IV = 160'h67452301_efcdab89_98badcfe_10325476_c3d2e1f0;

  logic [31:0] a, b, c, d, e;
  logic [31:0] w [16];
  logic [159:0] cv, start;
  logic [5:0] pair;
  logic run, fin;
  logic [1:0] rnd;
  logic [31:0] k, mid, nxt_a, n16, n17, x16, x17;

  function automatic logic [31:0] fsel(input logic [1:0] r, input logic [31:0] x, y, z);
    case (r)
      2'd0:    return (x & y) | (~x & z);
      2'd2:    return (x & y) | (x & z) | (y & z);
      default: return x ^ y ^ z;
    endcase
  endfunction

  assign rnd = (pair < 6'd10) ? 2'd0 : (pair < 6'd20) ? 2'd1 : (pair < 6'd30) ? 2'd2 : 2'd3;

  always_comb begin
    case (rnd)
      2'd0:    k = 32'h5a827999;
      2'd1:    k = 32'h6ed9eba1;
      2'd2:    k = 32'h8f1bbcdc;
      default: k = 32'hca62c1d6;
    endcase
  end

  assign mid   = {a[26:0], a[31:27]} + fsel(rnd, b, c, d) + e + w[0] + k;
  assign nxt_a = {mid[26:0], mid[31:27]} + fsel(rnd, a, {b[1:0], b[31:2]}, c) + d + w[1] + k;

  assign x16 = w[13] ^ w[8] ^ w[2] ^ w[0];
  assign x17 = w[14] ^ w[9] ^ w[3] ^ w[1];
  assign n16 = {x16[30:0], x16[31]};
  assign n17 = {x17[30:0], x17[31]};

  assign blk_ready = !run && !fin;
  assign start     = chain_en ? digest : IV;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run    <= 1'b0;
      fin    <= 1'b0;
      done   <= 1'b0;
      pair   <= '0;
      digest <= IV;
      cv     <= '0;
      {a, b, c, d, e} <= '0;
      for (int i = 0; i < 16; i++) w[i] <= '0;
    end else begin
      done <= 1'b0;
      if (blk_valid && blk_ready) begin
        cv   <= start;
        {a, b, c, d, e} <= start;
        for (int i = 0; i < 16; i++) w[i] <= blk_data[511 - 32*i -: 32];
        pair <= '0;
        run  <= 1'b1;
      end else if (run) begin
        a <= nxt_a;
        b <= mid;
        c <= {a[1:0], a[31:2]};
        d <= {b[1:0], b[31:2]};
        e <= c;
        for (int i = 0; i < 14; i++) w[i] <= w[i+2];
        w[14] <= n16;
        w[15] <= n17;
        pair  <= pair + 6'd1;
        if (pair == LAST) begin
          run <= 1'b0;
          fin <= 1'b1;
        end
      end else if (fin) begin
        fin    <= 1'b0;
        done   <= 1'b1;
        digest <= {cv[159:128] + a, cv[127:96] + b, cv[95:64] + c, cv[63:32] + d, cv[31:0] + e};
      end
    end
  end
endmodule

// File: rtl/sha1_dual_core_chk.sv
module sha1_dual_core_chk (
  input logic         clk,
  input logic         rst_n,
  input logic         blk_valid,
  input logic         blk_ready,
  input logic [159:0] digest,
  input logic         done
);
  localparam int LAT = 42;
  logic [6:0] since;

  always_ff @(posedge clk) begin
    if (!rst_n) since <= '0;
    else if (blk_valid && blk_ready) since <= 7'd1;
    else if (done) since <= '0;
    else if (since != 7'd0) since <= since + 7'd1;
  end

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R3
  AST_DONE_LATENCY:   assert property (@(posedge clk) disable iff (!rst_n) done |-> since == 7'(LAT)); // R3
  AST_STALL_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n) (blk_valid && blk_ready) |=> !blk_ready); // R2
  AST_READY_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n) $rose(blk_ready) |-> done); // R2
  AST_DIGEST_HOLD:    assert property (@(posedge clk) disable iff (!rst_n) !done |-> $stable(digest)); // R7
endmodule

bind sha1_dual_core sha1_dual_core_chk i_chk (
  .clk(clk), .rst_n(rst_n), .blk_valid(blk_valid), .blk_ready(blk_ready),
  .digest(digest), .done(done)
);

// File: tb/test_sha1_dual_core.sv
module test_sha1_dual_core;
  localparam int PERIOD = 10;
  localparam logic [159:0] IV = 160'h67452301_efcdab89_98badcfe_10325476_c3d2e1f0;

  logic clk = 0, rst_n = 0, blk_valid = 0, chain_en = 0;
  logic [511:0] blk_data = '0;
  logic blk_ready, done;
  logic [159:0] digest;
  int n_chk = 0, n_fail = 0;
  logic [159:0] prev = IV;
  logic [31:0] seed = 32'h1234_5678;

  sha1_dual_core i_sha1_dual_core (.*);

  always #(PERIOD/2) clk = ~clk;

  function automatic logic [31:0] rl(input logic [31:0] x, input int n);
    return (x << n) | (x >> (32 - n));
  endfunction

  function automatic logic [159:0] ref_hash(input logic [159:0] h, input logic [511:0] m);
    logic [31:0] wt [80];
    logic [31:0] va, vb, vc, vd, ve, f, kk, t;
    for (int i = 0; i < 16; i++) wt[i] = m[511 - 32*i -: 32];
    for (int i = 16; i < 80; i++) wt[i] = rl(wt[i-3] ^ wt[i-8] ^ wt[i-14] ^ wt[i-16], 1);
    {va, vb, vc, vd, ve} = h;
    for (int i = 0; i < 80; i++) begin
      if (i < 20)      begin f = (vb & vc) | (~vb & vd);             kk = 32'h5a827999; end
      else if (i < 40) begin f = vb ^ vc ^ vd;                        kk = 32'h6ed9eba1; end
      else if (i < 60) begin f = (vb & vc) | (vb & vd) | (vc & vd);   kk = 32'h8f1bbcdc; end
      else             begin f = vb ^ vc ^ vd;                        kk = 32'hca62c1d6; end
      t  = rl(va, 5) + f + ve + wt[i] + kk;
      ve = vd; vd = vc; vc = rl(vb, 30); vb = va; va = t;
    end
    return {h[159:128] + va, h[127:96] + vb, h[95:64] + vc, h[63:32] + vd, h[31:0] + ve};
  endfunction

  task automatic chk(input logic ok, input string req, input logic [159:0] act, input logic [159:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] nxt(input logic [31:0] s);
    logic [31:0] x = s;
    x ^= x << 13; x ^= x >> 17; x ^= x << 5;
    return x;
  endfunction

  task automatic run_block(input logic [511:0] data, input logic ch, input logic poke,
                           input logic [159:0] known, input logic use_known);
    logic [159:0] exp;
    logic bad;
    exp = ref_hash(ch ? prev : IV, data);
    if (use_known) chk(exp == known, "R4 bench model", exp, known);
    @(negedge clk);
    chk(blk_ready == 1'b1, "R2 ready before accept", {159'd0, blk_ready}, 160'd1);
    blk_valid = 1; blk_data = data; chain_en = ch;
    @(negedge clk);
    blk_valid = 0; blk_data = ~data; chain_en = ~ch;
    bad = (blk_ready != 0) || (done != 0);
    for (int i = 1; i <= 40; i++) begin
      @(negedge clk);
      if (poke && i == 5) begin blk_valid = 1; blk_data = {16{32'hdeadbeef}}; chain_en = 0; end
      if (poke && i == 9) blk_valid = 0;
      if (blk_ready != 0 || done != 0) bad = 1;
    end
    chk(!bad, "R2 R3 R6 stall without early done", {158'd0, blk_ready, done}, 160'd0);
    blk_valid = 0;
    @(negedge clk);
    chk(done == 1'b1 && blk_ready == 1'b1, "R3 done at latency", {158'd0, blk_ready, done}, 160'd3);
    chk(digest == exp, ch ? "R5 chained digest" : "R4 digest", digest, exp);
    prev = exp;
    @(negedge clk);
    chk(done == 1'b0, "R3 R6 single pulse", {159'd0, done}, 160'd0);
  endtask

  initial begin
    #(PERIOD * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [511:0] blk;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(blk_ready == 1'b1 && done == 1'b0, "R1 reset handshake", {158'd0, blk_ready, done}, 160'd2);
    chk(digest == IV, "R1 reset digest", digest, IV);

    run_block({32'h61626380, 448'd0, 32'h00000018}, 0, 0,
              160'ha9993e36_4706816a_ba3e2571_7850c26c_9cd0d89d, 1);
    run_block('0, 1, 0, '0, 0);
    run_block({512{1'b1}}, 0, 1, '0, 0);
    for (int n = 0; n < 30; n++) begin
      for (int j = 0; j < 16; j++) begin
        seed = nxt(seed);
        blk[511 - 32*j -: 32] = seed;
      end
      run_block(blk, n[0], n % 4 == 2, '0, 0);
    end

    blk_valid = 0;
    repeat (6) @(negedge clk);
    chk(digest == prev && done == 0, "R7 digest held idle", digest, prev);

    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule